// File: doc/BRIEF.md
# Addressed Multi-Drop Serial Write Receiver

This block receives register writes from a shared three-wire bus: a serial clock, a serial data line and one enable line. Several devices listen on the same wires, and each one has its own 8-bit identity. A transfer has two phases. First the host clocks out a device identity and raises the enable line. Then it clocks out a 16-bit program word and lowers the enable line. Both fields are sent least significant bit first.

All three bus wires are synchronised into the system clock. The receiver shifts in one data bit on each synchronised rising edge of the serial clock. When the enable line rises, it compares the most recent eight bits with its own identity. When the enable line falls, and only if that compare matched, it splits the most recent sixteen bits into a 7-bit register address and 9-bit register data and pulses a write strobe for one system clock. There is no read path.

Top module: `mdrop_wr_rx`

## Requirements
- R1: Out of reset `wr_stb` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A data bit is taken only on a synchronised rising edge of `ser_clk`. The serial-clock bit counter does not change unless such an edge or an enable edge occurs.
- R3: On a rising edge of `ser_en`, the eight most recently received bits, with the first one received as bit 0, are compared with `OWN_ID` (default 8'h8C). The result is kept as the match state.
- R4: On a falling edge of `ser_en` with the match state set, the sixteen most recently received bits form a word W, with the first one received as W[0]. Then `wr_addr` = W[15:9], `wr_data` = W[8:0], and `wr_stb` is high for one cycle on the third system clock edge after `ser_en` goes low, which is two synchroniser stages plus the output register.
- R5: A device identity that differs from `OWN_ID` produces no strobe, and `wr_addr` and `wr_data` keep their values.
- R6: The match state is cleared at every falling edge of `ser_en`. A data phase whose own address phase did not match produces no write, even if an earlier transfer matched.
- R7: Transfers work both with the serial clock idling low and with it idling high between transfers.
- R8: An address phase with fewer than 8 serial clocks never matches. A data phase with fewer than 16 serial clocks never writes.
- R9: The bit counter restarts at every enable edge and saturates at 16. When a phase carries more clocks than it needs, only its most recent bits are used.
- R10: `wr_stb` is never high on two consecutive cycles, is high only one cycle after a detected enable fall with the match state set, and `wr_addr` and `wr_data` change only in a cycle where `wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Bus serial clock, asynchronous |
| ser_dat | input | 1 | Bus serial data, sampled on ser_clk rising |
| ser_en | input | 1 | Bus enable: rising frames the address, falling frames the data |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the last write |
| wr_data | output | 9 | Register data of the last write |

## Verification
On every cycle, the assertions check the following. The strobe is a single-cycle pulse that follows a detected enable fall and a set match state. The match state is gone after every enable fall. The bit counter clears at each enable edge, never exceeds sixteen, and moves only on serial clock edges. The output fields hold between strobes.

Only the bench scenarios can show the rest. These are the bit order and the field split of real words, the identity compare against the default value, the strobe latency, both serial clock idle levels, and the handling of phases that are too short or too long.

// File: rtl/mdrop_pkg.sv
`timescale 1ns/1ps
package mdrop_pkg;
  localparam int ID_W    = 8;
  localparam int WORD_W  = 16;
  localparam int RADDR_W = 7;
  localparam int RDATA_W = WORD_W - RADDR_W;
  localparam int CNT_W   = $clog2(WORD_W + 1);

  typedef struct packed {
    logic [RADDR_W-1:0] addr;
    logic [RDATA_W-1:0] data;
  } reg_wr_t;

  // first bit received ends up at bit 0 after WORD_W shifts
  function automatic logic [WORD_W-1:0] shift_lsb_first(
      input logic [WORD_W-1:0] sr, input logic b);
    return {b, sr[WORD_W-1:1]};
  endfunction

  // the last ID_W bits received sit at the top of the register
  function automatic logic [ID_W-1:0] recent_id(input logic [WORD_W-1:0] sr);
    return sr[WORD_W-1 -: ID_W];
  endfunction

  function automatic reg_wr_t split_word(input logic [WORD_W-1:0] w);
    reg_wr_t r;
    r.addr = w[WORD_W-1 -: RADDR_W];
    r.data = w[RDATA_W-1:0];
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(WORD_W)) ? c : c + CNT_W'(1);
  endfunction
endpackage

// File: rtl/mdrop_sync.sv
`timescale 1ns/1ps
module mdrop_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = pipe[STAGES-1];
endmodule

// File: rtl/mdrop_edge.sv
`timescale 1ns/1ps
module mdrop_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] =  lvl[i] & ~lvl_q[i];
      assign fall[i] = ~lvl[i] &  lvl_q[i];
    end
  endgenerate
endmodule

// File: rtl/mdrop_shift.sv
`timescale 1ns/1ps
module mdrop_shift
  import mdrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              cnt_clr,
  output logic [WORD_W-1:0] sr,
  output logic [CNT_W-1:0]  cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (shift_en) begin
      sr <= shift_lsb_first(sr, bit_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      cnt <= sat_inc(cnt);
    end
  end
endmodule

// File: rtl/mdrop_frame.sv
`timescale 1ns/1ps
module mdrop_frame
  import mdrop_pkg::*;
#(
  parameter logic [ID_W-1:0] OWN_ID = 8'h8C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_rise,
  input  logic               en_fall,
  input  logic [WORD_W-1:0]  sr,
  input  logic [CNT_W-1:0]   cnt,
  output logic               id_match,
  output logic               wr_stb,
  output logic [RADDR_W-1:0] wr_addr,
  output logic [RDATA_W-1:0] wr_data
);
  logic    addr_ok;
  logic    word_ok;
  reg_wr_t fields;

  assign addr_ok = (cnt >= CNT_W'(ID_W)) && (recent_id(sr) == OWN_ID);
  assign word_ok = (cnt == CNT_W'(WORD_W));
  assign fields  = split_word(sr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_match <= 1'b0;
    end else if (en_rise) begin
      id_match <= addr_ok;
    end else if (en_fall) begin
      id_match <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (en_fall && id_match && word_ok) begin
        wr_stb  <= 1'b1;
        wr_addr <= fields.addr;
        wr_data <= fields.data;
      end
    end
  end
endmodule

// File: rtl/mdrop_wr_rx.sv
`timescale 1ns/1ps
module mdrop_wr_rx
  import mdrop_pkg::*;
#(
  parameter logic [7:0] OWN_ID      = 8'h8C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_en,
  output logic       wr_stb,
  output logic [6:0] wr_addr,
  output logic [8:0] wr_data
);
  localparam int IDX_CLK = 0;
  localparam int IDX_EN  = 1;
  localparam int IDX_DAT = 2;

  logic [2:0]        bus_sync;
  logic [1:0]        ev_rise;
  logic [1:0]        ev_fall;
  logic              sclk_rise;
  logic              en_rise;
  logic              en_fall;
  logic              id_match;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  mdrop_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ser_dat, ser_en, ser_clk}),
    .d_sync  (bus_sync)
  );

  mdrop_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (bus_sync[IDX_EN:IDX_CLK]),
    .rise  (ev_rise),
    .fall  (ev_fall)
  );

  assign sclk_rise = ev_rise[IDX_CLK];
  assign en_rise   = ev_rise[IDX_EN];
  assign en_fall   = ev_fall[IDX_EN];

  mdrop_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .bit_in   (bus_sync[IDX_DAT]),
    .cnt_clr  (en_rise | en_fall),
    .sr       (shreg),
    .cnt      (bit_cnt)
  );

  mdrop_frame #(.OWN_ID(OWN_ID)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .sr       (shreg),
    .cnt      (bit_cnt),
    .id_match (id_match),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  logic unused_fall_clk;
  assign unused_fall_clk = ev_fall[IDX_CLK];
endmodule

// File: rtl/mdrop_wr_rx_chk.sv
`timescale 1ns/1ps
module mdrop_wr_rx_chk
  import mdrop_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_rise,
  input logic             en_rise,
  input logic             en_fall,
  input logic             id_match,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             wr_stb,
  input logic [6:0]       wr_addr,
  input logic [8:0]       wr_data
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(en_fall) && $past(id_match)));

  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable({wr_addr, wr_data}));

  a_r6_match_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !id_match);

  a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise || en_fall) |=> (bit_cnt == '0));

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  a_r2_cnt_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !en_rise && !en_fall) |=> $stable(bit_cnt));
endmodule

bind mdrop_wr_rx mdrop_wr_rx_chk u_chk (.*);

// File: tb/test_mdrop_wr_rx.sv
`timescale 1ns/1ps
module test_mdrop_wr_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_en = 1'b0;
  logic       wr_stb;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_stb = 0;
  int n_dbl = 0;
  logic stb_prev = 1'b0;
  logic [6:0] cap_addr;
  logic [8:0] cap_data;
  bit idle_hi = 1'b0;

  always #2.5 clk = ~clk;

  mdrop_wr_rx i_mdrop_wr_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en(ser_en), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      n_stb++;
      cap_addr = wr_addr;
      cap_data = wr_data;
      if (stb_prev) n_dbl++;
    end
    stb_prev = wr_stb;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n bits of v, first bit = v[0]
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      if (idle_hi) ser_clk = 1'b0;
      ser_dat = v[i];
      wait_cyc(8);
      ser_clk = 1'b1;
      wait_cyc(8);
      if (!idle_hi) ser_clk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [31:0] idv, input int idn,
                      input logic [31:0] wv, input int wn,
                      input bit expect_wr, input logic [15:0] w,
                      input string req);
    int s0, lat, d0;
    logic [6:0] a0;
    logic [8:0] dt0;
    s0 = n_stb; d0 = n_dbl; a0 = wr_addr; dt0 = wr_data; lat = 0;
    ser_clk = idle_hi;
    wait_cyc(8);
    send_bits(idv, idn);
    wait_cyc(8);
    ser_en = 1'b1;
    wait_cyc(8);
    send_bits(wv, wn);
    wait_cyc(8);
    ser_en = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (wr_stb && lat == 0) lat = k;
    end
    wait_cyc(4);
    if (expect_wr) begin
      check(n_stb - s0 == 1, req, "strobe count", n_stb - s0, 1);
      check(lat == 3, req, "strobe latency", lat, 3);
      check(cap_addr == w[15:9], req, "wr_addr", cap_addr, w[15:9]);
      check(cap_data == w[8:0], req, "wr_data", cap_data, w[8:0]);
    end else begin
      check(n_stb == s0, req, "no strobe", n_stb - s0, 0);
      check(wr_addr == a0 && wr_data == dt0, req, "fields held",
            {wr_addr, wr_data}, {a0, dt0});
    end
    check(n_dbl == d0, "R10", "double strobe", n_dbl - d0, 0);
  endtask

  task automatic t_reset;
    check(wr_stb == 1'b0, "R1", "reset wr_stb", wr_stb, 0);
    check(wr_addr == '0 && wr_data == '0, "R1", "reset fields",
          {wr_addr, wr_data}, 0);
  endtask

  task automatic t_basic;   // R2 R3 R4: idle low
    idle_hi = 1'b0;
    xfer(32'h8C, 8, 32'hA5C3, 16, 1'b1, 16'hA5C3, "R4");
    xfer(32'h8C, 8, 32'h01FF, 16, 1'b1, 16'h01FF, "R3");
    xfer(32'h8C, 8, 32'hFE00, 16, 1'b1, 16'hFE00, "R2");
  endtask

  task automatic t_idle_high;
    idle_hi = 1'b1;
    xfer(32'h8C, 8, 32'h1234, 16, 1'b1, 16'h1234, "R7");
    idle_hi = 1'b0;
  endtask

  task automatic t_wrong_id;
    xfer(32'h8D, 8, 32'h5555, 16, 1'b0, 16'h0, "R5");
    xfer(32'h0C, 8, 32'h5555, 16, 1'b0, 16'h0, "R5");
  endtask

  task automatic t_match_cleared;
    xfer(32'h8C, 8, 32'h3C3C, 16, 1'b1, 16'h3C3C, "R6");
    xfer(32'h8C, 5, 32'h7777, 16, 1'b0, 16'h0, "R6");
  endtask

  task automatic t_short;
    xfer(32'h8C, 7, 32'h4242, 16, 1'b0, 16'h0, "R8");
    xfer(32'h8C, 8, 32'h4242, 12, 1'b0, 16'h0, "R8");
  endtask

  task automatic t_long;
    xfer({22'h0, 8'h8C, 2'b11}, 10, {12'h0, 16'hBEEF, 4'hF}, 20,
         1'b1, 16'hBEEF, "R9");
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_basic();
    t_idle_high();
    t_wrong_id();
    t_match_cleared();
    t_short();
    t_long();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule